// File: doc/BRIEF.md
# Fractional-Rate Master Counter

This block is a free-running 64-bit time base. It advances at a constant average rate, such as 6.144 MHz, whatever frequency the clock that drives it has. On every clock edge a fractional accumulator adds a programmed numerator. When the running total reaches a programmed denominator, the denominator is taken off and the main count steps by one. Over time the count therefore advances by numerator/denominator per input clock.

Software chooses the ratio to match the input clock: 8/25 at 19.2 MHz, 4/25 at 38.4 MHz, 64/125 at 12 MHz, 768/1625 at 13 MHz, 384/1625 at 26 MHz and 256/1125 at 27 MHz. Each ratio yields 6.144 MHz.

Registers are reached through a simple strobe bus with registered read data. The count can be preloaded and is read as two 32-bit words. The whole count is also driven out live on `count_out` for downstream timers.

Top module: `frac_rate_counter`

## Requirements
- R1: After reset the numerator, denominator and both count words read as zero, and the count does not move until a nonzero denominator is written.
- R2: Byte offsets: count low word 0x00, count high word 0x04, numerator 0x10, denominator 0x14. The numerator and denominator are the 12-bit fields in bits [11:0]. Bits [31:12] of these registers ignore writes and read as zero. Any other offset reads as zero. Read data appears on the cycle after the read strobe and holds until the next read.
- R3: With 0 < den and num < den, the count is pre + floor(k*num/den) once k clock edges have passed since the edge that wrote the denominator. Here pre is the count value held at that write.
- R4: Outside load cycles, the count changes by zero or one per clock.
- R5: While the denominator is zero, the count holds its value.
- R6: With a nonzero denominator and num >= den, the count advances by exactly one per clock.
- R7: A write to the denominator clears the fractional accumulator. No step occurs on the edge of that write.
- R8: The count is 64 bits, and a carry out of the low word reaches the high word.
- R9: A read of the low word captures the high word at the same edge. A later read of the high word returns that captured value, even if the live count has since changed.
- R10: A write to a count word loads that word. In that cycle the load replaces the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock of any supported frequency |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| count_out | output | 64 | Live count value |

## Verification
Some rules are checked by assertions on every cycle:
- the accumulator always stays below a nonzero denominator;
- the accumulator is zero after a denominator write;
- the count steps by at most one per clock, holds while the denominator is zero, and steps by exactly one in full-rate mode;
- reserved bits read as zero.

Other behaviour shows only in the bench scenarios. These cover the long-run average floor(k*num/den) for every ratio in a small sweep and for the six clock ratios, carry into the high word, the high-word capture against a moving count, and load priority over increment.

// File: rtl/frc_pkg.sv
package frc_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CNT_LO,
      SEL_CNT_HI,
      SEL_NUM,
      SEL_DEN
   } reg_sel_e;

   function automatic reg_sel_e decode_sel(input logic [31:0] a,
                                           input logic [31:0] ofs_lo,
                                           input logic [31:0] ofs_hi,
                                           input logic [31:0] ofs_num,
                                           input logic [31:0] ofs_den);
      reg_sel_e s;
      if (a == ofs_lo)       s = SEL_CNT_LO;
      else if (a == ofs_hi)  s = SEL_CNT_HI;
      else if (a == ofs_num) s = SEL_NUM;
      else if (a == ofs_den) s = SEL_DEN;
      else                   s = SEL_NONE;
      return s;
   endfunction

endpackage

// File: rtl/frc_accum.sv
module frc_accum #(
   parameter int FRAC_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FRAC_W-1:0] num_i,
   input  logic [FRAC_W-1:0] den_i,
   input  logic              clear_i,
   output logic              step_o
);
   localparam int SUM_W = FRAC_W + 1;

   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W-1:0] acc_d;
   logic [SUM_W-1:0]  sum;
   logic [SUM_W-1:0]  diff;
   logic              active;
   logic              saturate;
   logic              over;

   always_comb begin
      active   = (den_i != '0);
      saturate = (num_i >= den_i);
      sum      = {1'b0, acc_q} + {1'b0, num_i};
      diff     = sum - {1'b0, den_i};
      over     = (sum >= {1'b0, den_i});
      step_o   = 1'b0;
      acc_d    = acc_q;
      if (clear_i) begin
         acc_d = '0;
      end else if (active) begin
         if (saturate) begin
            step_o = 1'b1;
            acc_d  = '0;
         end else if (over) begin
            step_o = 1'b1;
            acc_d  = diff[FRAC_W-1:0];
         end else begin
            acc_d  = sum[FRAC_W-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
   end

   // R3: remainder stays below a nonzero denominator
   a_r3_acc_below_den: assert property (@(posedge clk) disable iff (!rst_n)
      (den_i != '0) |-> (acc_q < den_i));

   // R7: denominator write leaves a cleared remainder
   a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (acc_q == '0));

endmodule

// File: rtl/frc_count.sv
module frc_count #(
   parameter int CNT_W = 64,
   parameter int BUS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             ld_lo_i,
   input  logic             ld_hi_i,
   input  logic [BUS_W-1:0] ld_data_i,
   output logic [CNT_W-1:0] count_o
);
   localparam int HI_W = CNT_W - BUS_W;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             any_ld;

   always_comb begin
      any_ld = ld_lo_i | ld_hi_i;
      cnt_d  = any_ld ? cnt_q : (cnt_q + CNT_W'(step_i));
      if (ld_lo_i) cnt_d[BUS_W-1:0]     = ld_data_i;
      if (ld_hi_i) cnt_d[CNT_W-1:BUS_W] = ld_data_i[HI_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign count_o = cnt_q;

   // R4: no more than one step per clock outside loads
   a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !any_ld |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(1)));

endmodule

// File: rtl/frc_regs.sv
module frc_regs
   import frc_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int BUS_W   = 32,
   parameter int FRAC_W  = 12,
   parameter int CNT_W   = 64,
   parameter bit HI_SNAP = 1'b1,
   parameter int OFS_LO  = 'h00,
   parameter int OFS_HI  = 'h04,
   parameter int OFS_NUM = 'h10,
   parameter int OFS_DEN = 'h14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BUS_W-1:0]  wdata_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic [FRAC_W-1:0] num_o,
   output logic [FRAC_W-1:0] den_o,
   output logic              den_wr_o,
   output logic              ld_lo_o,
   output logic              ld_hi_o,
   output logic [BUS_W-1:0]  rdata_o
);
   localparam int HI_W = CNT_W - BUS_W;

   reg_sel_e          sel;
   logic [FRAC_W-1:0] num_q;
   logic [FRAC_W-1:0] den_q;
   logic [BUS_W-1:0]  rdata_q;
   logic [BUS_W-1:0]  rd_mux;
   logic [HI_W-1:0]   hi_view;
   logic              rd_lo;

   assign sel      = decode_sel(32'(addr_i), 32'(OFS_LO), 32'(OFS_HI),
                                32'(OFS_NUM), 32'(OFS_DEN));
   assign den_wr_o = wr_i && (sel == SEL_DEN);
   assign ld_lo_o  = wr_i && (sel == SEL_CNT_LO);
   assign ld_hi_o  = wr_i && (sel == SEL_CNT_HI);
   assign rd_lo    = rd_i && (sel == SEL_CNT_LO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         num_q <= '0;
         den_q <= '0;
      end else if (wr_i) begin
         if (sel == SEL_NUM) num_q <= wdata_i[FRAC_W-1:0];
         if (sel == SEL_DEN) den_q <= wdata_i[FRAC_W-1:0];
      end
   end

   generate
      if (HI_SNAP) begin : g_snap
         logic [HI_W-1:0] shadow_q;
         always_ff @(posedge clk) begin
            if (!rst_n)     shadow_q <= '0;
            else if (rd_lo) shadow_q <= count_i[CNT_W-1:BUS_W];
         end
         assign hi_view = shadow_q;

         // R9: captured high word changes only on a low-word read
         a_r9_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_lo |=> $stable(shadow_q));
      end else begin : g_live
         assign hi_view = count_i[CNT_W-1:BUS_W];
      end
   endgenerate

   always_comb begin
      case (sel)
         SEL_CNT_LO: rd_mux = count_i[BUS_W-1:0];
         SEL_CNT_HI: rd_mux = BUS_W'(hi_view);
         SEL_NUM:    rd_mux = BUS_W'(num_q);
         SEL_DEN:    rd_mux = BUS_W'(den_q);
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    rdata_q <= '0;
      else if (rd_i) rdata_q <= rd_mux;
   end

   assign num_o   = num_q;
   assign den_o   = den_q;
   assign rdata_o = rdata_q;

   // R2: reserved bits of the ratio registers read as zero
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && (sel == SEL_NUM || sel == SEL_DEN)) |=> (rdata_o[BUS_W-1:FRAC_W] == '0));

endmodule

// File: rtl/frac_rate_counter.sv
module frac_rate_counter #(
   parameter int ADDR_W  = 8,
   parameter int BUS_W   = 32,
   parameter int FRAC_W  = 12,
   parameter int CNT_W   = 64,
   parameter bit HI_SNAP = 1'b1,
   parameter int OFS_LO  = 'h00,
   parameter int OFS_HI  = 'h04,
   parameter int OFS_NUM = 'h10,
   parameter int OFS_DEN = 'h14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic [CNT_W-1:0]  count_out
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (CNT_W <= BUS_W || CNT_W > 2 * BUS_W) begin : g_bad_cnt
         $error("CNT_W must lie in (BUS_W, 2*BUS_W]");
      end
      if (FRAC_W < 1 || FRAC_W >= BUS_W) begin : g_bad_frac
         $error("FRAC_W must lie in [1, BUS_W)");
      end
      if (OFS_LO >= ADDR_SPAN || OFS_HI >= ADDR_SPAN ||
          OFS_NUM >= ADDR_SPAN || OFS_DEN >= ADDR_SPAN) begin : g_bad_ofs
         $error("register offset outside address range");
      end
      if (OFS_LO == OFS_HI || OFS_LO == OFS_NUM || OFS_LO == OFS_DEN ||
          OFS_HI == OFS_NUM || OFS_HI == OFS_DEN || OFS_NUM == OFS_DEN) begin : g_dup_ofs
         $error("register offsets must differ");
      end
   endgenerate

   logic [FRAC_W-1:0] num;
   logic [FRAC_W-1:0] den;
   logic              den_wr;
   logic              ld_lo;
   logic              ld_hi;
   logic              step;

   frc_regs #(
      .ADDR_W (ADDR_W), .BUS_W (BUS_W), .FRAC_W (FRAC_W), .CNT_W (CNT_W),
      .HI_SNAP(HI_SNAP), .OFS_LO(OFS_LO), .OFS_HI(OFS_HI),
      .OFS_NUM(OFS_NUM), .OFS_DEN(OFS_DEN)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (bus_wr),
      .rd_i    (bus_rd),
      .addr_i  (bus_addr),
      .wdata_i (bus_wdata),
      .count_i (count_out),
      .num_o   (num),
      .den_o   (den),
      .den_wr_o(den_wr),
      .ld_lo_o (ld_lo),
      .ld_hi_o (ld_hi),
      .rdata_o (bus_rdata)
   );

   frc_accum #(.FRAC_W(FRAC_W)) u_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .num_i  (num),
      .den_i  (den),
      .clear_i(den_wr),
      .step_o (step)
   );

   frc_count #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_i   (step),
      .ld_lo_i  (ld_lo),
      .ld_hi_i  (ld_hi),
      .ld_data_i(bus_wdata),
      .count_o  (count_out)
   );

   // R5: zero denominator freezes the count
   a_r5_den_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (den == '0 && !ld_lo && !ld_hi) |=> $stable(count_out));

   // R6: ratio at or above one gives one step per clock
   a_r6_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
      (den != '0 && num >= den && !ld_lo && !ld_hi && !den_wr)
         |=> (count_out == $past(count_out) + CNT_W'(1)));

endmodule

// File: tb/frac_rate_counter_bench.sv
`timescale 1ns/1ps
module frac_rate_counter_bench;

   localparam logic [7:0] A_LO  = 8'h00;
   localparam logic [7:0] A_HI  = 8'h04;
   localparam logic [7:0] A_NUM = 8'h10;
   localparam logic [7:0] A_DEN = 8'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] count_out;

   int vectors = 0;
   int misses  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   frac_rate_counter u_frac_rate_counter (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .count_out(count_out)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd64(output logic [63:0] v);
      logic [31:0] lo, hi;
      rd(A_LO, lo);
      rd(A_HI, hi);
      v = {hi, lo};
   endtask

   // stop, preload, program ratio, run k edges, read back
   task automatic run_case(input string tag, input int num, input int den,
                           input logic [63:0] pre, input int k);
      logic [63:0] got, exp;
      wr(A_DEN, 32'd0);
      wr(A_NUM, 32'(num));
      wr(A_LO, pre[31:0]);
      wr(A_HI, pre[63:32]);
      wr(A_DEN, 32'(den));
      idle(k);
      rd64(got);
      if (num >= den) exp = pre + 64'(k);
      else            exp = pre + (64'(k) * 64'(num)) / 64'(den);
      chk(tag, got, exp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         misses++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [63:0] v, prev;
      int bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values and no motion
      rd(A_NUM, d); chk("R1 num", 64'(d), 64'd0);
      rd(A_DEN, d); chk("R1 den", 64'(d), 64'd0);
      idle(10);
      rd64(v);      chk("R1 count", v, 64'd0);
      chk("R1 count_out", count_out, 64'd0);

      // R2: field width, reserved bits, unmapped offset
      wr(A_NUM, 32'hFFFFF008);
      rd(A_NUM, d); chk("R2 num field", 64'(d), 64'h008);
      wr(A_DEN, 32'hABCDE019);
      rd(A_DEN, d); chk("R2 den field", 64'(d), 64'h019);
      rd(8'h20, d); chk("R2 unmapped", 64'(d), 64'd0);
      idle(3);
      chk("R2 rdata hold", 64'(bus_rdata), 64'd0);

      // R5: zero denominator holds a preloaded count
      wr(A_DEN, 32'd0);
      wr(A_LO, 32'd123);
      wr(A_HI, 32'd0);
      idle(40);
      rd64(v); chk("R5 hold", v, 64'd123);

      // R6 and R8: full rate across the low-word boundary
      run_case("R8 carry", 1, 1, 64'h7_FFFFFFFA, 20);
      run_case("R6 num>den", 9, 4, 64'd500, 33);

      // R7: rewriting the denominator discards the remainder
      wr(A_DEN, 32'd0);
      wr(A_NUM, 32'd1);
      wr(A_LO, 32'd0);
      wr(A_HI, 32'd0);
      wr(A_DEN, 32'd3);
      idle(2);
      wr(A_DEN, 32'd3);
      idle(2);
      rd(A_LO, d); chk("R7 clear", 64'(d), 64'd0);

      // R9: captured high word against a moving count
      wr(A_DEN, 32'd0);
      wr(A_NUM, 32'd1);
      wr(A_LO, 32'hFFFFFFF0);
      wr(A_HI, 32'd2);
      wr(A_DEN, 32'd1);
      idle(3);
      rd(A_LO, d); chk("R9 low", 64'(d), 64'hFFFFFFF3);
      idle(30);
      rd(A_HI, d); chk("R9 captured high", 64'(d), 64'd2);
      rd(A_LO, d);
      rd(A_HI, d); chk("R9 new high", 64'(d), 64'd3);

      // R10: a load beats the increment of the same edge
      wr(A_LO, 32'd100);
      rd(A_LO, d); chk("R10 load low", 64'(d), 64'd100);
      wr(A_HI, 32'h55);
      rd(A_LO, d);
      rd(A_HI, d); chk("R10 load high", 64'(d), 64'h55);

      // R4: live count moves by at most one per clock
      run_case("R3 7/25", 7, 25, 64'd0, 10);
      bad = 0;
      prev = count_out;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (count_out - prev > 64'd1) bad++;
         prev = count_out;
      end
      chk("R4 step size", 64'(bad), 64'd0);

      // R3: near-exhaustive sweep of small ratios
      for (int dn = 1; dn <= 6; dn++)
         for (int nm = 0; nm <= dn + 1; nm++)
            run_case("R3 sweep", nm, dn, 64'(1000 * dn + nm), 2 * dn + 3);

      // R3: ratios for the supported input clocks
      run_case("R3 19.2MHz", 8,   25,   64'h1_0000_0000, 3 * 25 + 11);
      run_case("R3 38.4MHz", 4,   25,   64'd77,          3 * 25 + 11);
      run_case("R3 12MHz",   64,  125,  64'd0,           3 * 125 + 11);
      run_case("R3 13MHz",   768, 1625, 64'hFFFF_FF00,   3 * 1625 + 11);
      run_case("R3 26MHz",   384, 1625, 64'd9,           3 * 1625 + 11);
      run_case("R3 27MHz",   256, 1125, 64'd31,          3 * 1125 + 11);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule